// File: doc/BRIEF.md
# Prescaled Timer and Watchdog Unit

This block keeps an 8-bit timer that software can read and write. The timer advances once per power-of-two group of clock-enable ticks and emits a one-cycle pulse each time it wraps. Beside it runs an 8-bit watchdog counter with its own power-of-two prescaler. A time-out of the watchdog produces a one-cycle reset pulse, which clears the timer and the watchdog. A control register holds both prescale selects and an interrupt-disable bit. Two status flags report the power state and the time-out state of the system.

The CPU that owns the block does three things. It writes the control register. It issues a watchdog-clear strobe often enough to avoid a time-out. It raises a sleep strobe when it powers down. The two flags let startup code tell apart a cold start, a watchdog time-out and a wake from sleep. The time-out flag is set at power-on and by a watchdog clear, and it drops on a time-out. The power-down flag is set at power-on and by a watchdog clear, it drops on sleep entry, and a time-out leaves it unchanged.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After power-on reset (`por_n` low), the block shows these values. `tmr_q` is 0x00. `ctl_q` reads 0xBF: bits [6:0] reset to 0x3F and bit 7 always reads 1. `flag_to` and `flag_pd` are 1. `tmr_ovf` and `wdt_rst` are 0.
- R2: `ctl_q[5:3]` is the timer select. Select code k makes the timer advance once every 2^(k+1) rising edges that have `tick_en` high, so codes 0 to 7 divide by 2 to 256.
- R3: When the timer steps from 0xFF to 0x00, `tmr_ovf` is high for exactly the one cycle after that edge.
- R4: A `tmr_we` cycle loads `tmr_wdata` into the timer and clears the timer prescaler. The load takes priority over a step in the same cycle. After the load, the next step comes a full prescale period later.
- R5: A `ctl_we` cycle stores `ctl_wdata` into bits [6:0] of the control register. Bit 7 reads 1 whatever value is written.
- R6: `ctl_q[2:0]` is the watchdog select. Select code k steps the watchdog once every 2^k enabled ticks, so codes 0 to 7 divide by 1 to 128. The 256th step after a clear is the time-out. A time-out holds `wdt_rst` high for the one following cycle and returns the timer and the watchdog counter to zero.
- R7: The watchdog counts and times out only while both `wdt_enable` and `wdt_opt` are 1. Otherwise it holds its count.
- R8: A `wdt_clr` cycle zeroes the watchdog counter and its prescaler and sets `flag_to` and `flag_pd`. In the same cycle it blocks any time-out.
- R9: A time-out clears `flag_to` and leaves `flag_pd` as it was.
- R10: A `sleep_req` cycle clears `flag_pd` and does not change `flag_to`. If `wdt_clr` is high in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_en | input | 1 | Clock-enable tick feeding both prescalers |
| wdt_opt | input | 1 | Static option; 0 keeps the watchdog off |
| wdt_enable | input | 1 | Watchdog enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_q | output | 8 | Control register value |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| tmr_q | output | 8 | Timer value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| sleep_req | input | 1 | Sleep entry strobe |
| tmr_ovf | output | 1 | Timer wrap pulse |
| wdt_rst | output | 1 | Watchdog reset pulse |
| flag_to | output | 1 | Time-out flag (0 after a watchdog time-out) |
| flag_pd | output | 1 | Power-down flag (0 after sleep entry) |

## Verification
The prescaler tables are offset from each other by one bit. The bench therefore counts edges at timer ratios 2, 4, 16 and 256 and at watchdog ratios 1, 2 and 4. It places the time-out exactly on the 256th step, so a design that used the wrong table or stopped at 255 would reset one period early or late. A clear issued just after a single tick exposes a design that forgot to zero the watchdog prescaler, because that design would time out 511 ticks after the clear instead of 512. A timer reload over a partial prescale count catches a design that kept the stale count, since its first step would come too soon. The flag tests step through sleep, then a time-out, then a clear. A design that dropped the power-down flag on a time-out, or let sleep beat a simultaneous clear, reports the wrong status.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef struct packed {
      logic to;
      logic pd;
   } tw_flags_t;
endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
   parameter int SEL_W  = 3,
   parameter int OFFSET = 0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             fire
);
   localparam int PRE_W = (1 << SEL_W) - 1 + OFFSET;

   if (OFFSET < 0 || OFFSET > 1) begin : g_bad_offset
      $error("tw_prescaler: OFFSET must be 0 or 1");
   end

   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] mask;

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (32'(sel) + 32'(OFFSET)) > 32'(i);
   end

   assign fire = tick && ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wipe,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         wrap
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         q    <= '0;
         wrap <= 1'b0;
      end else begin
         wrap <= 1'b0;
         if (wipe)      q <= '0;
         else if (load) q <= load_val;
         else if (step) begin
            q    <= q + 1'b1;
            wrap <= &q;
         end
      end
   end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog
   import tw_pkg::*;
#(
   parameter int W = 8
) (
   input  logic      clk,
   input  logic      por_n,
   input  logic      run,
   input  logic      step,
   input  logic      kick,
   input  logic      sleep,
   output logic      bite_now,
   output logic      bite,
   output tw_flags_t flags
);
   logic [W-1:0] cnt;

   assign bite_now = run && step && (&cnt) && !kick;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt      <= '0;
         bite     <= 1'b0;
         flags.to <= 1'b1;
         flags.pd <= 1'b1;
      end else begin
         bite <= bite_now;
         if (kick) begin
            cnt      <= '0;
            flags.to <= 1'b1;
            flags.pd <= 1'b1;
         end else begin
            if (bite_now) begin
               cnt      <= '0;
               flags.to <= 1'b0;
            end else if (run && step) begin
               cnt <= cnt + 1'b1;
            end
            if (sleep) flags.pd <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
   import tw_pkg::*;
#(
   parameter int TMR_W = 8,
   parameter int WDT_W = 8,
   parameter int SEL_W = 3,
   localparam int CTL_W = 2 * SEL_W + 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick_en,
   input  logic             wdt_opt,
   input  logic             wdt_enable,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_q,
   input  logic             tmr_we,
   input  logic [TMR_W-1:0] tmr_wdata,
   output logic [TMR_W-1:0] tmr_q,
   input  logic             wdt_clr,
   input  logic             sleep_req,
   output logic             tmr_ovf,
   output logic             wdt_rst,
   output logic             flag_to,
   output logic             flag_pd
);
   localparam logic [CTL_W-1:0] TOP_ONE  = {1'b1, {(CTL_W-1){1'b0}}};
   localparam logic [CTL_W-1:0] SEL_ONES = CTL_W'((1 << (2 * SEL_W)) - 1);
   localparam logic [CTL_W-1:0] CTL_RST  = TOP_ONE | SEL_ONES;

   if (TMR_W < 2 || WDT_W < 2) begin : g_bad_width
      $error("tmr_wdog_unit: counters need at least 2 bits");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("tmr_wdog_unit: SEL_W must lie in 1..4");
   end

   logic [CTL_W-1:0] ctl_r;
   logic [SEL_W-1:0] t_sel, w_sel;
   logic             wd_run, t_fire, w_fire, bite_now;
   tw_flags_t        fl;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ctl_r <= CTL_RST;
      else if (ctl_we) ctl_r <= ctl_wdata | TOP_ONE;
   end

   assign t_sel  = ctl_r[2*SEL_W-1:SEL_W];
   assign w_sel  = ctl_r[SEL_W-1:0];
   assign wd_run = wdt_enable && wdt_opt;

   tw_prescaler #(.SEL_W(SEL_W), .OFFSET(1)) u_tpre (
      .clk  (clk),
      .por_n(por_n),
      .tick (tick_en),
      .clr  (tmr_we | bite_now),
      .sel  (t_sel),
      .fire (t_fire)
   );

   tw_prescaler #(.SEL_W(SEL_W), .OFFSET(0)) u_wpre (
      .clk  (clk),
      .por_n(por_n),
      .tick (tick_en & wd_run),
      .clr  (wdt_clr),
      .sel  (w_sel),
      .fire (w_fire)
   );

   tw_timer #(.W(TMR_W)) u_tmr (
      .clk     (clk),
      .por_n   (por_n),
      .wipe    (bite_now),
      .load    (tmr_we),
      .load_val(tmr_wdata),
      .step    (t_fire),
      .q       (tmr_q),
      .wrap    (tmr_ovf)
   );

   tw_watchdog #(.W(WDT_W)) u_wdt (
      .clk     (clk),
      .por_n   (por_n),
      .run     (wd_run),
      .step    (w_fire),
      .kick    (wdt_clr),
      .sleep   (sleep_req),
      .bite_now(bite_now),
      .bite    (wdt_rst),
      .flags   (fl)
   );

   assign ctl_q   = ctl_r;
   assign flag_to = fl.to;
   assign flag_pd = fl.pd;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
   parameter int TMR_W = 8,
   parameter int SEL_W = 3,
   localparam int CTL_W = 2 * SEL_W + 2
) (
   input logic             clk,
   input logic             por_n,
   input logic             wdt_opt,
   input logic             wdt_enable,
   input logic [CTL_W-1:0] ctl_q,
   input logic             tmr_we,
   input logic [TMR_W-1:0] tmr_wdata,
   input logic [TMR_W-1:0] tmr_q,
   input logic             wdt_clr,
   input logic             sleep_req,
   input logic             tmr_ovf,
   input logic             wdt_rst,
   input logic             flag_to,
   input logic             flag_pd
);
   a_r3_ovf_pulse: assert property (@(posedge clk) disable iff (!por_n)
      tmr_ovf |=> !tmr_ovf);
   a_r3_ovf_zero: assert property (@(posedge clk) disable iff (!por_n)
      tmr_ovf |-> tmr_q == '0);
   a_r4_load: assert property (@(posedge clk) disable iff (!por_n)
      tmr_we |=> (tmr_q == $past(tmr_wdata)) || wdt_rst);
   a_r5_top_bit: assert property (@(posedge clk) disable iff (!por_n)
      ctl_q[CTL_W-1]);
   a_r6_rst_clears: assert property (@(posedge clk) disable iff (!por_n)
      wdt_rst |-> tmr_q == '0);
   a_r7_gated: assert property (@(posedge clk) disable iff (!por_n)
      wdt_rst |-> $past(wdt_enable && wdt_opt));
   a_r8_kick: assert property (@(posedge clk) disable iff (!por_n)
      wdt_clr |=> flag_to && flag_pd && !wdt_rst);
   a_r9_to_low: assert property (@(posedge clk) disable iff (!por_n)
      wdt_rst |-> !flag_to);
   a_r9_pd_kept: assert property (@(posedge clk) disable iff (!por_n)
      wdt_rst && !$past(sleep_req) |-> flag_pd == $past(flag_pd));
   a_r10_sleep: assert property (@(posedge clk) disable iff (!por_n)
      sleep_req && !wdt_clr |=> !flag_pd);
endmodule

bind tmr_wdog_unit tw_checker #(.TMR_W(TMR_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_tmr_wdog_unit.sv
module tb_tmr_wdog_unit;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick_en = 1'b0, wdt_opt = 1'b1, wdt_enable = 1'b0;
   logic       ctl_we = 1'b0, tmr_we = 1'b0, wdt_clr = 1'b0, sleep_req = 1'b0;
   logic [7:0] ctl_wdata = '0, tmr_wdata = '0;
   logic [7:0] ctl_q, tmr_q;
   logic       tmr_ovf, wdt_rst, flag_to, flag_pd;
   int         n_chk = 0, n_fail = 0, ovf_seen = 0, rst_seen = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   tmr_wdog_unit dut (
      .clk(clk), .por_n(por_n), .tick_en(tick_en), .wdt_opt(wdt_opt),
      .wdt_enable(wdt_enable), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_q(ctl_q), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
      .wdt_clr(wdt_clr), .sleep_req(sleep_req), .tmr_ovf(tmr_ovf),
      .wdt_rst(wdt_rst), .flag_to(flag_to), .flag_pd(flag_pd)
   );

   always @(negedge clk) begin
      if (tmr_ovf) ovf_seen++;
      if (wdt_rst) rst_seen++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      #1;
   endtask

   task automatic set_ctl(input logic [7:0] v);
      ctl_wdata = v; ctl_we = 1'b1;
      @(negedge clk); ctl_we = 1'b0; #1;
   endtask

   task automatic load_tmr(input logic [7:0] v);
      tmr_wdata = v; tmr_we = 1'b1;
      @(negedge clk); tmr_we = 1'b0; #1;
   endtask

   task automatic kick();
      wdt_clr = 1'b1;
      @(negedge clk); wdt_clr = 1'b0; #1;
   endtask

   task automatic t_reset();
      chk("R1 timer", tmr_q, 8'h00);
      chk("R1 ctl", ctl_q, 8'hBF);
      chk("R1 to", flag_to, 1);
      chk("R1 pd", flag_pd, 1);
      chk("R1 pulses", {tmr_ovf, wdt_rst}, 0);
   endtask

   task automatic t_ctl();
      set_ctl(8'h00); chk("R5 top bit", ctl_q, 8'h80);
      set_ctl(8'h7F); chk("R5 all", ctl_q, 8'hFF);
   endtask

   task automatic t_ratio();
      set_ctl(8'h00); load_tmr(8'h00); ticks(7);
      chk("R2 ratio 2", tmr_q, 3);
      set_ctl(8'h18); load_tmr(8'h00); ticks(40);
      chk("R2 ratio 16", tmr_q, 2);
      set_ctl(8'h38); load_tmr(8'h00); ticks(600);
      chk("R2 ratio 256", tmr_q, 2);
   endtask

   task automatic t_wrap();
      int base;
      set_ctl(8'h00); load_tmr(8'hFE);
      base = ovf_seen;
      ticks(3);
      chk("R3 no early pulse", ovf_seen - base, 0);
      chk("R3 at FF", tmr_q, 8'hFF);
      ticks(1);
      chk("R3 pulse", ovf_seen - base, 1);
      chk("R3 wrapped", tmr_q, 0);
      @(negedge clk); #1;
      chk("R3 single pulse", ovf_seen - base, 1);
   endtask

   task automatic t_load();
      set_ctl(8'h08);
      load_tmr(8'h10); ticks(3);
      load_tmr(8'h20); ticks(3);
      chk("R4 prescaler cleared", tmr_q, 8'h20);
      ticks(1);
      chk("R4 full period", tmr_q, 8'h21);
      set_ctl(8'h00);
      tick_en = 1'b1; tmr_wdata = 8'h30; tmr_we = 1'b1;
      @(negedge clk); tmr_we = 1'b0; tick_en = 1'b0; #1;
      chk("R4 load beats step", tmr_q, 8'h30);
      ticks(2);
      chk("R4 after load", tmr_q, 8'h31);
   endtask

   task automatic t_wdt_timeout();
      int base;
      wdt_opt = 1'b1; wdt_enable = 1'b1;
      set_ctl(8'h38); kick(); load_tmr(8'h55);
      base = rst_seen;
      ticks(255);
      chk("R6 no early time-out", rst_seen - base, 0);
      chk("R6 timer intact", tmr_q, 8'h55);
      ticks(1);
      chk("R6 time-out at 256", rst_seen - base, 1);
      chk("R6 timer cleared", tmr_q, 0);
      chk("R9 to cleared", flag_to, 0);
      chk("R9 pd kept", flag_pd, 1);
      set_ctl(8'h02); kick();
      base = rst_seen;
      ticks(1023);
      chk("R6 ratio 4 early", rst_seen - base, 0);
      ticks(1);
      chk("R6 ratio 4 time-out", rst_seen - base, 1);
      wdt_enable = 1'b0;
   endtask

   task automatic t_gate();
      int base;
      set_ctl(8'h00); kick();
      base = rst_seen;
      wdt_opt = 1'b0; wdt_enable = 1'b1; ticks(300);
      chk("R7 option off", rst_seen - base, 0);
      wdt_opt = 1'b1; wdt_enable = 1'b0; ticks(300);
      chk("R7 enable off", rst_seen - base, 0);
      wdt_enable = 1'b1; ticks(255);
      chk("R7 count held", rst_seen - base, 0);
      ticks(1);
      chk("R7 resumes", rst_seen - base, 1);
      wdt_enable = 1'b0;
   endtask

   task automatic t_kick();
      int base;
      wdt_enable = 1'b1;
      set_ctl(8'h00); kick();
      base = rst_seen;
      ticks(200); kick(); ticks(200);
      chk("R8 kick restarts", rst_seen - base, 0);
      chk("R8 flags set", {flag_to, flag_pd}, 2'b11);
      set_ctl(8'h01); kick(); ticks(1); kick();
      base = rst_seen;
      ticks(511);
      chk("R8 prescaler zeroed", rst_seen - base, 0);
      ticks(1);
      chk("R8 full period", rst_seen - base, 1);
      wdt_enable = 1'b0;
   endtask

   task automatic t_sleep();
      kick();
      sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0; #1;
      chk("R10 pd cleared", flag_pd, 0);
      chk("R10 to kept", flag_to, 1);
      wdt_enable = 1'b1; set_ctl(8'h00);
      ticks(256);
      chk("R9 to after sleep", flag_to, 0);
      chk("R9 pd retained", flag_pd, 0);
      wdt_enable = 1'b0;
      kick();
      chk("R8 kick restores", {flag_to, flag_pd}, 2'b11);
      sleep_req = 1'b1; wdt_clr = 1'b1;
      @(negedge clk); sleep_req = 1'b0; wdt_clr = 1'b0; #1;
      chk("R10 clear wins", flag_pd, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_ctl();
      t_ratio();
      t_wrap();
      t_load();
      t_wdt_timeout();
      t_gate();
      t_kick();
      t_sleep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule